// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Bit Shifter

This block runs the bit-level side of a three-wire serial EEPROM link. It drives the serial clock and the data line and samples the data line. Software first loads the data register. It then writes a command: a direction flag, a request to release the data line, and a bit count. That command write is the only start trigger. The engine issues that many serial clock pulses. On a transmit it sends bits from the top of the data register. On a receive it samples the line and collects the bits into the low end of the register. It raises busy while clocking and pulses a completion interrupt when it finishes. The chip select line, opcode sequencing and any EEPROM protocol above single bits are handled elsewhere.

The controller is a three-state machine. `ST_IDLE` waits for a command. `ST_LO` holds SCLK low for one half period. `ST_HI` holds SCLK high for one half period. Its transitions are as follows.

- `ST_IDLE -> ST_LO`: a command with a non-zero count is accepted.
- `ST_IDLE -> ST_IDLE`: a zero-count command only applies the drive setting.
- `ST_LO -> ST_HI`: at the half-period tick, SCLK rises and a receive samples the line.
- `ST_HI -> ST_LO`: at the tick, SCLK falls and a transmit presents its next bit, while bits remain.
- `ST_HI -> ST_IDLE`: at the tick on the last bit, busy drops and the interrupt fires.

A phase timer sets each half period to `HALF_DIV` system clocks.

Top module: `ee3w_shifter`

## Requirements
- R1: After reset, sclk is 0, sdata_oe is 0, busy is 0, irq is 0 and data_q is 0.
- R2: A ctrl_we pulse seen while idle with an effective count n>0 raises busy from the next cycle. Busy then stays high for exactly 2*HALF_DIV*n cycles, during which n SCLK pulses are issued.
- R3: On a transmit (ctrl_rd=0), sdata_oe is 1 throughout the command. At the k-th SCLK rise (k from 0), sdata_o equals bit 7-k of the data register as loaded. Bit 7 is the most significant. At the end, data_q holds the loaded value shifted left by n, with zeros filled in.
- R4: On a receive (ctrl_rd=1), the n bits sampled at the SCLK rises land in data_q[n-1:0], first received in the highest of them. Bits above n-1 read 0.
- R5: SCLK is low whenever busy is low. sdata_o changes only while SCLK is low, so it is stable from each SCLK rise until the following fall.
- R6: During a receive, and after it ends, sdata_oe stays 0.
- R7: After the last bit of a transmit, sdata_oe equals the inverse of ctrl_hiz as given with the command.
- R8: A command with count 0 issues no SCLK pulse, never raises busy and leaves data_q unchanged. It sets sdata_oe to the inverse of ctrl_hiz and pulses irq in the following cycle.
- R9: irq is a one-cycle pulse. It occurs once per accepted command, in the first cycle in which busy is low again.
- R10: ctrl_we and data_we pulses that arrive while busy is high have no effect on the running command or on data_q.
- R11: A ctrl_cnt above 8 acts as a count of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_we | input | 1 | Load data register from data_wval (idle only) |
| data_wval | input | DATA_W | Value to load into the data register |
| ctrl_we | input | 1 | Command write; starts a command when idle |
| ctrl_rd | input | 1 | 1 = receive, 0 = transmit |
| ctrl_hiz | input | 1 | 1 = release the data line after a transmit or zero-count command |
| ctrl_cnt | input | CNT_W | Number of bits, 0 to 8 (larger is clamped) |
| data_q | output | DATA_W | Data register contents |
| busy | output | 1 | High while SCLK pulses are running |
| irq | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock to the EEPROM, idles low |
| sdata_o | output | 1 | Serial data output value |
| sdata_oe | output | 1 | Serial data output enable (0 = high impedance) |
| sdata_i | input | 1 | Serial data input from the line |

## Verification
The bench targets several distinct corner cases.

- A zero-count command: a design that clocks anyway, raises busy, or skips the interrupt shows stray pulses or a missing completion.
- A three-bit receive into a register preloaded with ones: if stale upper bits survive, or bits land left-justified, the read value is wrong.
- A count of twelve: without clamping, more than eight pulses and a longer busy window appear.
- Command and data writes injected mid-transfer: if they are accepted, the pulse count, shifted bits or final data change.
- Releasing or keeping the line after a transmit: an inverted or ignored high-impedance request shows up in the final enable.
- A driver left on during a receive: the monitor sees driven bits where none are expected.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } ee3w_state_e;

endpackage

// File: rtl/ee3w_phase_timer.sv
module ee3w_phase_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2
endmodule

// File: rtl/ee3w_shift_reg.sv
module ee3w_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         shift_out,
    input  logic         shift_in,
    input  logic         ser_in,
    output logic [W-1:0] data_q,
    output logic         msb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= load_val;
        end else if (clear) begin
            data_q <= '0;
        end else if (shift_out) begin
            data_q <= {data_q[W-2:0], 1'b0};
        end else if (shift_in) begin
            data_q <= {data_q[W-2:0], ser_in};
        end
    end

    assign msb = data_q[W-1];

    AST_ONE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_out && shift_in)); // R3
endmodule

// File: rtl/ee3w_ctrl_fsm.sv
module ee3w_ctrl_fsm
    import ee3w_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic             cmd_rd,
    input  logic             cmd_hiz,
    input  logic [CNT_W-1:0] cmd_cnt,
    input  logic             tick,
    output logic             busy,
    output logic             sclk,
    output logic             oe,
    output logic             irq,
    output logic             clr_data,
    output logic             shift_out,
    output logic             shift_in
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(W);

    ee3w_state_e       state_q, state_d;
    logic              rd_q, hiz_q, sclk_q, oe_q, irq_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  cnt_eff;
    logic              accept, last_bit;

    assign cnt_eff  = (cmd_cnt > MAX_CNT) ? MAX_CNT : cmd_cnt;
    assign accept   = cmd_we && (state_q == ST_IDLE);
    assign last_bit = (left_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && cnt_eff != '0) state_d = ST_LO;
            ST_LO:   if (tick) state_d = ST_HI;
            ST_HI:   if (tick) state_d = last_bit ? ST_IDLE : ST_LO;
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            hiz_q  <= 1'b0;
            sclk_q <= 1'b0;
            oe_q   <= 1'b0;
            irq_q  <= 1'b0;
            left_q <= '0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && cnt_eff == '0) begin
                        oe_q  <= !cmd_hiz;
                        irq_q <= 1'b1;
                    end else if (accept) begin
                        rd_q   <= cmd_rd;
                        hiz_q  <= cmd_hiz;
                        left_q <= cnt_eff;
                        oe_q   <= !cmd_rd;
                        sclk_q <= 1'b0;
                    end
                end
                ST_LO: begin
                    if (tick) sclk_q <= 1'b1;
                end
                ST_HI: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        left_q <= left_q - CNT_W'(1);
                        if (last_bit) begin
                            irq_q <= 1'b1;
                            if (!rd_q) oe_q <= !hiz_q;
                        end
                    end
                end
                default: sclk_q <= 1'b0;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign sclk      = sclk_q;
    assign oe        = oe_q;
    assign irq       = irq_q;
    assign clr_data  = accept && cmd_rd && (cnt_eff != '0);
    assign shift_out = (state_q == ST_HI) && tick && !rd_q;
    assign shift_in  = (state_q == ST_LO) && tick && rd_q;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sclk_q); // R5
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && rd_q) |-> !oe_q); // R6
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !rd_q) |-> oe_q); // R3
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R9
    AST_BUSY_END_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_q); // R9
    AST_LEFT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= MAX_CNT); // R11
    AST_BUSY_LOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we && !(state_q == ST_HI && tick && last_bit)) |=> busy); // R10
endmodule

// File: rtl/ee3w_shifter.sv
module ee3w_shifter #(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wval,
    input  logic              ctrl_we,
    input  logic              ctrl_rd,
    input  logic              ctrl_hiz,
    input  logic [CNT_W-1:0]  ctrl_cnt,
    output logic [DATA_W-1:0] data_q,
    output logic              busy,
    output logic              irq,
    output logic              sclk,
    output logic              sdata_o,
    output logic              sdata_oe,
    input  logic              sdata_i
);
    logic tick, clr_data, shift_out, shift_in;

    ee3w_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    ee3w_ctrl_fsm #(.W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (ctrl_we),
        .cmd_rd    (ctrl_rd),
        .cmd_hiz   (ctrl_hiz),
        .cmd_cnt   (ctrl_cnt),
        .tick      (tick),
        .busy      (busy),
        .sclk      (sclk),
        .oe        (sdata_oe),
        .irq       (irq),
        .clr_data  (clr_data),
        .shift_out (shift_out),
        .shift_in  (shift_in)
    );

    ee3w_shift_reg #(.W(DATA_W)) u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (data_we && !busy),
        .load_val  (data_wval),
        .clear     (clr_data),
        .shift_out (shift_out),
        .shift_in  (shift_in),
        .ser_in    (sdata_i),
        .data_q    (data_q),
        .msb       (sdata_o)
    );

    AST_SDATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata_o)); // R5
    AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(data_q) || $past(tick)); // R10
endmodule

// File: tb/ee3w_shifter_tb.sv
module ee3w_shifter_tb;
    localparam int HD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] data_wval = '0;
    logic       ctrl_we = 1'b0;
    logic       ctrl_rd = 1'b0;
    logic       ctrl_hiz = 1'b0;
    logic [3:0] ctrl_cnt = '0;
    logic [7:0] data_q;
    logic       busy, irq, sclk, sdata_o, sdata_oe, sdata_i;

    always #5 clk = ~clk;

    ee3w_shifter #(.DATA_W(8), .CNT_W(4), .HALF_DIV(HD)) u_dut (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wval(data_wval),
        .ctrl_we(ctrl_we), .ctrl_rd(ctrl_rd), .ctrl_hiz(ctrl_hiz), .ctrl_cnt(ctrl_cnt),
        .data_q(data_q), .busy(busy), .irq(irq), .sclk(sclk),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(sdata_i)
    );

    typedef struct {
        bit         is_done;
        logic [7:0] val;
        int         pulses;
        int         busyc;
        logic       oe;
        string      req;
    } exp_t;

    exp_t       q[$];
    int         vectors = 0;
    int         miscompares = 0;
    bit         finished = 0;
    logic [7:0] rd_pat = '0;
    int         fidx = 0;
    logic       prev_sclk = 1'b0;
    logic       prev_sdo = 1'b0;
    int         pulses = 0;
    int         busyc = 0;

    // EEPROM model: presents next bit after each SCLK fall
    assign sdata_i = (fidx < 8) ? rd_pat[3'(7 - fidx)] : 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items as the design produces them
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_sclk = 1'b0; pulses = 0; busyc = 0;
            end else begin
                if (busy) busyc++;
                if (!sclk && !busy && sdata_oe === 1'bx) check("R1", "oe unknown", 1, 0);
                if (sclk && prev_sclk && sdata_oe)
                    check("R5", "sdata moved while sclk high", sdata_o, prev_sdo);
                if (sclk && !prev_sclk) begin
                    pulses++;
                    if (sdata_oe) begin
                        if (q.size() == 0) check("R6", "driven bit with nothing expected", 1, 0);
                        else begin
                            e = q.pop_front();
                            if (e.is_done) check(e.req, "driven bit where completion expected", 1, 0);
                            else check(e.req, "serial bit", sdata_o, e.val[0]);
                        end
                    end
                end
                if (!sclk && prev_sclk) fidx++;
                if (!busy && sclk) check("R5", "sclk high while idle", sclk, 0);
                if (irq) begin
                    if (q.size() == 0) check("R9", "unexpected irq", 1, 0);
                    else begin
                        e = q.pop_front();
                        if (!e.is_done) check(e.req, "irq before all bits", 1, 0);
                        else begin
                            check(e.req, "data_q", data_q, e.val);
                            check(e.req, "sdata_oe after", sdata_oe, e.oe);
                            check(e.req, "sclk pulses", pulses, e.pulses);
                            check("R2", "busy cycles", busyc, e.busyc);
                            check("R9", "busy low at irq", busy, 0);
                        end
                    end
                    pulses = 0; busyc = 0;
                end
                prev_sclk = sclk;
                prev_sdo  = sdata_o;
            end
        end
    end

    task automatic run_cmd(input bit rd, input bit hiz, input logic [3:0] cnt,
                           input logic [7:0] data, input logic [7:0] pat,
                           input bit poke, input string req);
        int   n;
        exp_t e;
        n = (cnt > 8) ? 8 : int'(cnt);
        @(negedge clk); data_we = 1'b1; data_wval = data;
        @(negedge clk); data_we = 1'b0;
        if (!rd) begin
            for (int k = 0; k < n; k++) begin
                e.is_done = 0; e.val = {7'b0, data[7-k]}; e.pulses = 0;
                e.busyc = 0; e.oe = 1'b1; e.req = "R3";
                q.push_back(e);
            end
        end
        e.is_done = 1;
        if (n == 0)  e.val = data;
        else if (rd) e.val = pat >> (8 - n);
        else         e.val = data << n;
        e.oe     = (n == 0) ? !hiz : (rd ? 1'b0 : !hiz);
        e.pulses = n;
        e.busyc  = 2 * HD * n;
        e.req    = req;
        q.push_back(e);
        rd_pat = pat; fidx = 0;
        ctrl_rd = rd; ctrl_hiz = hiz; ctrl_cnt = cnt; ctrl_we = 1'b1;
        @(negedge clk); ctrl_we = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            ctrl_rd = 1'b1; ctrl_cnt = 4'd2; ctrl_we = 1'b1;
            data_we = 1'b1; data_wval = 8'h3C;
            @(negedge clk); ctrl_we = 1'b0; data_we = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(req, "idle after command", {busy, irq, sclk}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "sclk", sclk, 0);
        check("R1", "sdata_oe", sdata_oe, 0);
        check("R1", "busy", busy, 0);
        check("R1", "irq", irq, 0);
        check("R1", "data_q", data_q, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_cmd(1'b0, 1'b0, 4'd8,  8'hA5, 8'h00, 1'b0, "R7");  // full byte out, keep drive
        run_cmd(1'b0, 1'b1, 4'd6,  8'hC3, 8'h00, 1'b0, "R7");  // release after write
        run_cmd(1'b1, 1'b0, 4'd8,  8'h00, 8'h96, 1'b0, "R6");  // full byte in
        run_cmd(1'b0, 1'b0, 4'd0,  8'h96, 8'h00, 1'b0, "R8");  // zero count, take drive
        run_cmd(1'b1, 1'b0, 4'd3,  8'hFF, 8'hA0, 1'b0, "R4");  // short read, right justified
        run_cmd(1'b1, 1'b1, 4'd1,  8'h00, 8'h80, 1'b0, "R4");  // single bit in
        run_cmd(1'b0, 1'b0, 4'd12, 8'h5A, 8'h00, 1'b0, "R11"); // clamp to 8
        run_cmd(1'b0, 1'b0, 4'd4,  8'h93, 8'h00, 1'b1, "R10"); // writes while busy ignored
        run_cmd(1'b1, 1'b0, 4'd0,  8'h4E, 8'h00, 1'b0, "R8");  // zero count with read flag
        run_cmd(1'b0, 1'b1, 4'd0,  8'h11, 8'h00, 1'b0, "R8");  // zero count, release

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R2 watchdog actual=hung expected=idle");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule